// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer ALU

This block is a registered SIMD integer datapath that takes two wide source vectors and produces one result vector of the same width one clock after a valid strobe. The vector is cut into equal lanes of 8, 16 or 32 bits by a width code. One segmented carry chain, built from 8-bit segments, serves every width: at each lane's first segment the chain is cut and given a fresh carry-in, so no carry passes from one lane into the next.

An operation code chooses between add, subtract, absolute value, negate, signed or unsigned minimum, and signed or unsigned maximum. Abs and negate read only the first source. Min and max reuse the same adder as a lane comparator. For signed order the lane's top bit is inverted first, so an unsigned compare gives the signed result. A saturate flag turns add, subtract, abs and negate at 16-bit lanes into signed clamping operations. The clamp is asymmetric: positive overflow gives the largest positive value and negative overflow gives the most negative value. A surrounding vector pipeline drives the block once per operation and picks up the result and its valid flag on the next cycle.

Top module: `simd_alu`

## Requirements
- R1: `width_i` picks the lane size: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes, and 3 behaves exactly like 2. Lane i occupies bits [i*w +: w]. Wrapping results are taken modulo 2^w in each lane, and no carry or borrow crosses a lane edge.
- R2: `op_i` codes: 0 add (a+b), 1 subtract (a−b), 2 abs(a), 3 negate (−a), 4 signed min, 5 signed max, 6 unsigned min, 7 unsigned max. Without saturation, add and subtract wrap per lane. Add and subtract give the same bits whether the data are read as signed or unsigned.
- R3: With `sat_i`=1 at 16-bit lanes, add and subtract clamp per lane. Positive overflow gives 0x7fff and negative overflow gives 0x8000. Examples: 0x8000+0x8000 gives 0x8000 and 0x7000+0x2000 gives 0x7fff. Lanes that do not overflow give the exact sum.
- R4: Wrapping abs and negate of the most negative lane value return that same value (0x8000 at 16 bits, 0x80 at 8 bits). With `sat_i`=1 at 16-bit lanes, both return 0x7fff for 0x8000.
- R5: Signed min and max order the lanes as two's-complement values, and the unsigned forms order them as plain binary. With a=0x8000 and b=0x0001 at 16 bits, signed min is 0x8000, unsigned min is 0x0001, signed max is 0x0001 and unsigned max is 0x8000.
- R6: When the two lane operands are equal, min and max return the first source's lane.
- R7: `sat_i` has no effect at 8-bit or 32-bit lanes (and at width code 3), and no effect on the min and max codes. These cases give the plain wrapping or selected result.
- R8: The result is presented on `result_o` one clock edge after it is launched with `valid_i`=1. `valid_o` equals `valid_i` delayed by one cycle.
- R9: While `valid_i` is 0, `result_o` keeps its last value, whatever the source, op, width and saturate inputs do.
- R10: A synchronous active-high `rst` clears `result_o` and `valid_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Launch strobe for the operation on the inputs |
| src_a_i | input | VEC_W | First source vector (the only source for abs and negate) |
| src_b_i | input | VEC_W | Second source vector |
| op_i | input | 3 | Operation code (see R2) |
| width_i | input | 2 | Lane width code (see R1) |
| sat_i | input | 1 | Signed saturation select |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | VEC_W | Registered result vector |

## Verification
The assertions assume that `rst` is high on the first clock edges and that all control inputs are driven to known values at every edge. They also assume that `VEC_W` is a multiple of 32, so that every lane width tiles the vector exactly. Two of them cover only a subset of inputs: the saturating-add property applies when every 16-bit lane of both sources is non-negative, and the min/max property applies when both sources are identical. The stimulus changes inputs only on falling edges and keeps reset high until the bench starts. It mixes directed vectors that hit exactly these corners with random vectors whose bytes are often forced to 0x00, 0x7f, 0x80 or 0xff, which pushes lane edges and sign bits into overflow.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int SEG_W = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ABS  = 3'd2,
        OP_NEG  = 3'd3,
        OP_MINS = 3'd4,
        OP_MAXS = 3'd5,
        OP_MINU = 3'd6,
        OP_MAXU = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_RSV = 2'd3
    } lane_w_e;

endpackage

// File: rtl/simd_lane_bounds.sv
// Marks the first and last 8-bit segment of every lane for the chosen width.
module simd_lane_bounds
    import simd_alu_pkg::*;
#(
    parameter int NSEG = 64
) (
    input  lane_w_e         width_i,
    output logic [NSEG-1:0] seg_first_o,
    output logic [NSEG-1:0] seg_last_o
);

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam bit FIRST16 = (k % 2) == 0;
        localparam bit LAST16  = (k % 2) == 1;
        localparam bit FIRST32 = (k % 4) == 0;
        localparam bit LAST32  = (k % 4) == 3;

        assign seg_first_o[k] = (width_i == LW_8)  ? 1'b1 :
                                (width_i == LW_16) ? FIRST16 : FIRST32;
        assign seg_last_o[k]  = (width_i == LW_8)  ? 1'b1 :
                                (width_i == LW_16) ? LAST16 : LAST32;
    end

endmodule

// File: rtl/simd_lane_bcast.sv
// Copies a flag taken at each lane's top segment to every segment of that lane.
module simd_lane_bcast
    import simd_alu_pkg::*;
#(
    parameter int NSEG = 64
) (
    input  lane_w_e         width_i,
    input  logic [NSEG-1:0] top_flag_i,
    output logic [NSEG-1:0] lane_flag_o
);

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int TOP16 = k | 1;
        localparam int TOP32 = k | 3;

        assign lane_flag_o[k] = (width_i == LW_8)  ? top_flag_i[k]     :
                                (width_i == LW_16) ? top_flag_i[TOP16] :
                                                     top_flag_i[TOP32];
    end

endmodule

// File: rtl/simd_seg_adder.sv
// Segmented carry chain: the chain restarts with cin_i at each lane's first segment.
module simd_seg_adder
    import simd_alu_pkg::*;
#(
    parameter int NSEG = 64
) (
    input  logic [NSEG-1:0][SEG_W-1:0] x_i,
    input  logic [NSEG-1:0][SEG_W-1:0] y_i,
    input  logic [NSEG-1:0]            first_i,
    input  logic [NSEG-1:0]            cin_i,
    output logic [NSEG-1:0][SEG_W-1:0] sum_o,
    output logic [NSEG-1:0]            cout_o
);

    always_comb begin
        logic           carry;
        logic [SEG_W:0] part;
        carry = cin_i[0];
        for (int k = 0; k < NSEG; k++) begin
            if (first_i[k]) begin
                carry = cin_i[k];
            end
            part = {1'b0, x_i[k]} + {1'b0, y_i[k]} + {{SEG_W{1'b0}}, carry};
            sum_o[k]  = part[SEG_W-1:0];
            cout_o[k] = part[SEG_W];
            carry     = part[SEG_W];
        end
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = 512    // multiple of 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [VEC_W-1:0] src_a_i,
    input  logic [VEC_W-1:0] src_b_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       width_i,
    input  logic             sat_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] result_o
);

    localparam int NSEG = VEC_W / SEG_W;
    localparam logic [VEC_W-1:0] MSB16 = {(VEC_W/16){16'h8000}};

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] result;
    } stage_t;

    stage_t stage_d, stage_q;

    alu_op_e op;
    lane_w_e lw;
    assign op = alu_op_e'(op_i);
    assign lw = lane_w_e'(width_i);

    logic [NSEG-1:0][SEG_W-1:0] a_s, b_s, x_s, y_s, sum_s;
    logic [NSEG-1:0] cin_s, cout_s, seg_first, seg_last;
    logic [NSEG-1:0] a_top, a_neg_l, lane_ge;
    logic [NSEG-1:0] ovf_top, ovf_l, xneg_top, xneg_l;
    logic            is_arith, signed_cmp, sat_en;

    assign a_s = src_a_i;
    assign b_s = src_b_i;

    assign is_arith   = !op_i[2];
    assign signed_cmp = (op == OP_MINS) || (op == OP_MAXS);
    assign sat_en     = sat_i && (lw == LW_16) && is_arith;

    simd_lane_bounds #(.NSEG(NSEG)) u_bounds (
        .width_i     (lw),
        .seg_first_o (seg_first),
        .seg_last_o  (seg_last)
    );

    // sign of source a per lane, used by abs
    always_comb begin
        for (int k = 0; k < NSEG; k++) begin
            a_top[k] = a_s[k][SEG_W-1];
        end
    end

    simd_lane_bcast #(.NSEG(NSEG)) u_bc_sign (
        .width_i     (lw),
        .top_flag_i  (a_top),
        .lane_flag_o (a_neg_l)
    );

    // adder operand steering for every op
    always_comb begin
        logic [SEG_W-1:0] flip;
        for (int k = 0; k < NSEG; k++) begin
            flip = (signed_cmp && seg_last[k]) ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
            unique case (op)
                OP_ADD: begin
                    x_s[k] = a_s[k]; y_s[k] = b_s[k]; cin_s[k] = 1'b0;
                end
                OP_SUB: begin
                    x_s[k] = a_s[k]; y_s[k] = ~b_s[k]; cin_s[k] = 1'b1;
                end
                OP_ABS: begin
                    x_s[k]   = '0;
                    y_s[k]   = a_neg_l[k] ? ~a_s[k] : a_s[k];
                    cin_s[k] = a_neg_l[k];
                end
                OP_NEG: begin
                    x_s[k] = '0; y_s[k] = ~a_s[k]; cin_s[k] = 1'b1;
                end
                OP_MINS, OP_MINU: begin
                    // carry out of b - a set means b >= a: keep a
                    x_s[k] = b_s[k] ^ flip; y_s[k] = ~(a_s[k] ^ flip); cin_s[k] = 1'b1;
                end
                default: begin
                    // carry out of a - b set means a >= b: keep a
                    x_s[k] = a_s[k] ^ flip; y_s[k] = ~(b_s[k] ^ flip); cin_s[k] = 1'b1;
                end
            endcase
        end
    end

    simd_seg_adder #(.NSEG(NSEG)) u_adder (
        .x_i     (x_s),
        .y_i     (y_s),
        .first_i (seg_first),
        .cin_i   (cin_s),
        .sum_o   (sum_s),
        .cout_o  (cout_s)
    );

    // signed overflow and its direction, evaluated at each segment's top bit
    always_comb begin
        for (int k = 0; k < NSEG; k++) begin
            xneg_top[k] = x_s[k][SEG_W-1];
            ovf_top[k]  = (x_s[k][SEG_W-1] == y_s[k][SEG_W-1]) &&
                          (sum_s[k][SEG_W-1] != x_s[k][SEG_W-1]);
        end
    end

    simd_lane_bcast #(.NSEG(NSEG)) u_bc_ge (
        .width_i     (lw),
        .top_flag_i  (cout_s),
        .lane_flag_o (lane_ge)
    );

    simd_lane_bcast #(.NSEG(NSEG)) u_bc_ovf (
        .width_i     (lw),
        .top_flag_i  (ovf_top),
        .lane_flag_o (ovf_l)
    );

    simd_lane_bcast #(.NSEG(NSEG)) u_bc_xneg (
        .width_i     (lw),
        .top_flag_i  (xneg_top),
        .lane_flag_o (xneg_l)
    );

    // next state
    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = valid_i;
        if (valid_i) begin
            for (int k = 0; k < NSEG; k++) begin
                if (is_arith) begin
                    stage_d.result[k*SEG_W +: SEG_W] = sum_s[k];
                    if (sat_en && ovf_l[k]) begin
                        // negative overflow -> most negative, positive -> most positive
                        stage_d.result[k*SEG_W +: SEG_W] = seg_last[k] ?
                            {xneg_l[k], {(SEG_W-1){~xneg_l[k]}}} :
                            {SEG_W{~xneg_l[k]}};
                    end
                end else begin
                    stage_d.result[k*SEG_W +: SEG_W] = lane_ge[k] ? a_s[k] : b_s[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign valid_o  = stage_q.valid;
    assign result_o = stage_q.result;

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_o == $past(valid_i)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(valid_i)) |-> $stable(result_o));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid_o && result_o == '0));

    assert_sat_abs_pos_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd2 && sat_i && width_i == 2'd1)
        |=> ((result_o & MSB16) == '0));

    assert_sat_add_pos_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd0 && sat_i && width_i == 2'd1 &&
         (src_a_i & MSB16) == '0 && (src_b_i & MSB16) == '0)
        |=> ((result_o & MSB16) == '0));

    assert_minmax_equal_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i[2] && src_a_i == src_b_i) |=> (result_o == $past(src_a_i)));

endmodule

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;

    localparam int VW = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [VW-1:0] src_a_i = '0;
    logic [VW-1:0] src_b_i = '0;
    logic [2:0]    op_i = '0;
    logic [1:0]    width_i = '0;
    logic          sat_i = 1'b0;
    logic          valid_o;
    logic [VW-1:0] result_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    simd_alu #(.VEC_W(VW)) i_simd_alu (
        .clk(clk), .rst(rst), .valid_i(valid_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .op_i(op_i), .width_i(width_i), .sat_i(sat_i), .valid_o(valid_o), .result_o(result_o)
    );

    function automatic logic [VW-1:0] r8(input logic [7:0] v);   return {(VW/8){v}};  endfunction
    function automatic logic [VW-1:0] r16(input logic [15:0] v); return {(VW/16){v}}; endfunction
    function automatic logic [VW-1:0] r32(input logic [31:0] v); return {(VW/32){v}}; endfunction

    // lane-by-lane reference from the requirements
    function automatic logic [VW-1:0] ref_calc(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input logic [2:0] op, input logic [1:0] w,
                                               input logic s);
        int lw = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
        logic [VW-1:0] r = '0;
        for (int i = 0; i < VW / lw; i++) begin
            longint ua = 0;
            longint ub = 0;
            longint sa, sb, v;
            longint span = longint'(1) << lw;
            for (int j = 0; j < lw; j++) begin
                ua[j] = a[i*lw + j];
                ub[j] = b[i*lw + j];
            end
            sa = ua[lw-1] ? ua - span : ua;
            sb = ub[lw-1] ? ub - span : ub;
            case (op)
                3'd0: v = sa + sb;
                3'd1: v = sa - sb;
                3'd2: v = (sa < 0) ? -sa : sa;
                3'd3: v = -sa;
                3'd4: v = (sa <= sb) ? ua : ub;
                3'd5: v = (sa >= sb) ? ua : ub;
                3'd6: v = (ua <= ub) ? ua : ub;
                default: v = (ua >= ub) ? ua : ub;
            endcase
            if (s && lw == 16 && op < 3'd4) begin
                if (v > 32767)  v = 32767;
                if (v < -32768) v = -32768;
            end
            v = v & (span - 1);
            for (int j = 0; j < lw; j++) r[i*lw + j] = v[j];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // launch one op, sample one cycle later away from the edge
    task automatic apply(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [2:0] op,
                         input logic [1:0] w, input logic s, input logic [VW-1:0] exp,
                         input string tag);
        @(negedge clk);
        src_a_i = a; src_b_i = b; op_i = op; width_i = w; sat_i = s; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk(tag, result_o, exp);
        chk({tag, " R8 valid_o"}, {{(VW-1){1'b0}}, valid_o}, {{(VW-1){1'b0}}, 1'b1});
    endtask

    task automatic test_reset;
        chk("R10 reset result", result_o, '0);
        chk("R10 reset valid", {{(VW-1){1'b0}}, valid_o}, '0);
    endtask

    task automatic test_lane_carry;
        apply(r8(8'hff), r8(8'h01), 3'd0, 2'd0, 1'b0, r8(8'h00), "R1 w8 carry isolation");
        apply(r16(16'h00ff), r16(16'h0001), 3'd0, 2'd1, 1'b0, r16(16'h0100), "R1 w16 inner carry");
        apply(r32(32'h0000ffff), r32(32'h1), 3'd0, 2'd2, 1'b0, r32(32'h00010000), "R1 w32 inner carry");
        apply(r32(32'hffffffff), r32(32'h1), 3'd0, 2'd2, 1'b0, r32(32'h0), "R1 w32 wrap");
        apply(r32(32'h0000ffff), r32(32'h1), 3'd0, 2'd3, 1'b0, r32(32'h00010000), "R1 code3 as w32");
    endtask

    task automatic test_sub_wrap;
        apply(r16(16'h0000), r16(16'h0001), 3'd1, 2'd1, 1'b0, r16(16'hffff), "R2 w16 borrow wrap");
        apply(r8(8'h05), r8(8'h07), 3'd1, 2'd0, 1'b0, r8(8'hfe), "R2 w8 sub");
        apply(r16(16'h7000), r16(16'h2000), 3'd0, 2'd1, 1'b0, r16(16'h9000), "R2 w16 add wraps");
    endtask

    task automatic test_sat_addsub;
        apply(r16(16'h8000), r16(16'h8000), 3'd0, 2'd1, 1'b1, r16(16'h8000), "R3 neg clamp");
        apply(r16(16'h7000), r16(16'h2000), 3'd0, 2'd1, 1'b1, r16(16'h7fff), "R3 pos clamp");
        apply(r16(16'h0001), r16(16'h0001), 3'd0, 2'd1, 1'b1, r16(16'h0002), "R3 no overflow");
        apply(r16(16'h8000), r16(16'h0001), 3'd1, 2'd1, 1'b1, r16(16'h8000), "R3 sub neg clamp");
        apply(r16(16'h7fff), r16(16'hffff), 3'd1, 2'd1, 1'b1, r16(16'h7fff), "R3 sub pos clamp");
        apply(r32({16'h7000, 16'h8000}), r32({16'h2000, 16'h8000}), 3'd0, 2'd1, 1'b1,
              r32({16'h7fff, 16'h8000}), "R3 mixed lanes");
    endtask

    task automatic test_abs_neg;
        apply(r16(16'h8000), '0, 3'd2, 2'd1, 1'b0, r16(16'h8000), "R4 abs wrap min");
        apply(r16(16'h8000), '0, 3'd2, 2'd1, 1'b1, r16(16'h7fff), "R4 abs sat min");
        apply(r16(16'h8000), '0, 3'd3, 2'd1, 1'b0, r16(16'h8000), "R4 neg wrap min");
        apply(r16(16'h8000), '0, 3'd3, 2'd1, 1'b1, r16(16'h7fff), "R4 neg sat min");
        apply(r16(16'hffff), '0, 3'd2, 2'd1, 1'b0, r16(16'h0001), "R4 abs -1");
        apply(r16(16'h0005), '0, 3'd3, 2'd1, 1'b0, r16(16'hfffb), "R4 neg 5");
        apply(r8(8'h80), '0, 3'd2, 2'd0, 1'b0, r8(8'h80), "R4 abs w8 min");
    endtask

    task automatic test_minmax;
        apply(r16(16'h8000), r16(16'h0001), 3'd4, 2'd1, 1'b0, r16(16'h8000), "R5 signed min");
        apply(r16(16'h8000), r16(16'h0001), 3'd6, 2'd1, 1'b0, r16(16'h0001), "R5 unsigned min");
        apply(r16(16'h8000), r16(16'h0001), 3'd5, 2'd1, 1'b0, r16(16'h0001), "R5 signed max");
        apply(r16(16'h8000), r16(16'h0001), 3'd7, 2'd1, 1'b0, r16(16'h8000), "R5 unsigned max");
        apply(r8(8'hff), r8(8'h01), 3'd4, 2'd0, 1'b0, r8(8'hff), "R5 w8 signed min");
        apply(r32(32'h80000000), r32(32'h7fffffff), 3'd7, 2'd2, 1'b0, r32(32'h80000000), "R5 w32 unsigned max");
        apply(r16(16'h1234), r16(16'h1234), 3'd4, 2'd1, 1'b0, r16(16'h1234), "R6 equal min");
        apply(r8(8'h9a), r8(8'h9a), 3'd7, 2'd0, 1'b0, r8(8'h9a), "R6 equal max");
    endtask

    task automatic test_sat_ignored;
        apply(r8(8'h7f), r8(8'h01), 3'd0, 2'd0, 1'b1, r8(8'h80), "R7 sat at w8 wraps");
        apply(r32(32'h7fffffff), r32(32'h1), 3'd0, 2'd2, 1'b1, r32(32'h80000000), "R7 sat at w32 wraps");
        apply(r8(8'h80), '0, 3'd3, 2'd0, 1'b1, r8(8'h80), "R7 sat neg w8 wraps");
        apply(r16(16'h8000), r16(16'h0001), 3'd4, 2'd1, 1'b1, r16(16'h8000), "R7 sat on min");
        apply(r32(32'h7fffffff), r32(32'h1), 3'd0, 2'd3, 1'b1, r32(32'h80000000), "R7 sat code3 wraps");
    endtask

    task automatic test_hold;
        apply(r16(16'h0003), r16(16'h0004), 3'd0, 2'd1, 1'b0, r16(16'h0007), "R9 setup");
        @(negedge clk);
        src_a_i = r8(8'h55); src_b_i = r8(8'haa); op_i = 3'd3; width_i = 2'd0; sat_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 held while idle", result_o, r16(16'h0007));
        chk("R8 valid_o low when idle", {{(VW-1){1'b0}}, valid_o}, '0);
    endtask

    task automatic test_mid_reset;
        apply(r8(8'h11), r8(8'h22), 3'd0, 2'd0, 1'b0, r8(8'h33), "R10 setup");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 mid reset result", result_o, '0);
        chk("R10 mid reset valid", {{(VW-1){1'b0}}, valid_o}, '0);
        rst = 1'b0;
    endtask

    function automatic logic [VW-1:0] edge_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 8; i++) begin
            case ($urandom_range(0, 5))
                0: v[i*8 +: 8] = 8'h00;
                1: v[i*8 +: 8] = 8'h7f;
                2: v[i*8 +: 8] = 8'h80;
                3: v[i*8 +: 8] = 8'hff;
                default: v[i*8 +: 8] = 8'($urandom());
            endcase
        end
        return v;
    endfunction

    task automatic test_sweep;
        for (int rep = 0; rep < 3; rep++) begin
            for (int w = 0; w < 4; w++) begin
                for (int op = 0; op < 8; op++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [VW-1:0] a = edge_vec();
                        logic [VW-1:0] b = edge_vec();
                        apply(a, b, 3'(op), 2'(w), 1'(s),
                              ref_calc(a, b, 3'(op), 2'(w), 1'(s)), "R1 R2 R3 R4 R5 R7 sweep");
                    end
                end
            end
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_lane_carry();
        test_sub_wrap();
        test_sat_addsub();
        test_abs_neg();
        test_minmax();
        test_sat_ignored();
        test_hold();
        test_mid_reset();
        test_sweep();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule